// File: doc/BRIEF.md
# Interrupt Source Enable and Pending Register

This block gathers six interrupt sources from a data-acquisition card into one byte-wide register and drives a single combined request line to the host bus. Some sources produce pulses: the external trigger and a timer-counter output. The block latches these on their rising edge. The FIFO-condition source, and any other source not declared as pulse-type, is a level, and its pending bit follows the input.

Every source first passes through a two-flop synchronizer. A host write loads the six-bit enable mask. A host read returns the pending state ANDed with that mask. There is no separate clear register. To acknowledge a source, software writes the mask back with that bit cleared, which also empties the bit's edge latch, and then writes the bit set again. The pulse-type sources are chosen by the parameter `EDGE_SRC`. Its default marks bit 0 (external trigger) and bit 5 (timer counter 1) as edge-type; bit 2 (FIFO condition) and bits 1, 3 and 4 are level-type.

Top module: `irq_src_ctl`

## Requirements
- R1: After reset the enable mask and all edge latches are zero, so `rd_data` reads 0x00 and `irq` is low.
- R2: A cycle with `wr_en` high loads `wr_data[5:0]` into the enable mask. `rd_data[7:6]` always reads zero, whatever was written.
- R3: An edge-type source (bits 0 and 5) whose enable bit is 1 latches a rising edge of its input. The pending bit appears on `rd_data` three clock edges after the input is first sampled high.
- R4: An edge-type pending bit stays set after its input falls, for as long as its enable bit stays 1.
- R5: A level-type source (bit 2, and bits 1, 3 and 4) reads as pending two clock edges after its input is sampled high, and stops reading as pending two edges after the input is sampled low. It is never latched.
- R6: A rising edge that arrives while the source's enable bit is 0 is not latched, and it stays unseen after the bit is later set.
- R7: A write that clears an enable bit also clears that source's edge latch in the same cycle. Setting the bit again does not bring the old event back.
- R8: `irq` is high exactly when any bit of `rd_data` is high.
- R9: Writing 0x00 masks every source, so `rd_data` reads zero and `irq` is low from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 6 | Raw asynchronous interrupt source inputs |
| wr_en | input | 1 | Host write strobe for the enable mask |
| wr_data | input | 8 | Host write byte; bits 5:0 form the enable mask |
| rd_data | output | 8 | Pending sources ANDed with the enable mask; bits 7:6 zero |
| irq | output | 1 | Combined interrupt request |

## Verification
A write takes effect on `rd_data` one edge after the strobe is sampled. A level input shows on `rd_data` two edges after it is sampled, because of the synchronizer. A rising edge on a pulse-type source shows three edges after it is sampled, because the edge compare adds one more register. The bench drives inputs on the falling clock edge. It steps a reference model that carries these same delay stages once per rising edge, and it compares `rd_data` and `irq` at the next falling edge, so every check lands in the cycle where the requirement says the result is due. Directed sequences also sample explicitly one edge before a result is due and on the edge it is due, to pin the latency.

// File: rtl/irq_src_ctl.sv
module irq_src_ctl #(
  parameter int NSRC = 6,
  parameter int DW = 8,
  parameter logic [NSRC-1:0] EDGE_SRC = 6'b100001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic            irq
);
  localparam logic [NSRC-1:0] LEVEL_SRC = ~EDGE_SRC;

  logic [NSRC-1:0] sync1, sync2, prev, lat, en;
  logic [NSRC-1:0] rise, keep, pend;

  assign rise = sync2 & ~prev & EDGE_SRC;
  assign keep = wr_en ? wr_data[NSRC-1:0] : {NSRC{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      lat   <= '0;
      en    <= '0;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
      prev  <= sync2;
      lat   <= (lat | (rise & en)) & keep;
      if (wr_en) en <= wr_data[NSRC-1:0];
    end
  end

  assign pend    = ((lat & EDGE_SRC) | (sync2 & LEVEL_SRC)) & en;
  assign rd_data = {{(DW-NSRC){1'b0}}, pend};
  assign irq     = |pend;

  p_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:NSRC] == '0);

  p_lat_in_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat & ~en) == '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((lat & $past(lat)) == $past(lat)));

  p_clear_on_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((lat & ~$past(wr_data[NSRC-1:0])) == '0));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (rise & en) != '0) |=> ((lat & $past(rise & en)) == $past(rise & en)));

  p_mask_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[NSRC-1:0] == '0) |=> !irq);

  p_irq_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data != '0));
endmodule

// File: tb/irq_src_ctl_test.sv
module irq_src_ctl_test;
  localparam logic [5:0] EDGEM = 6'b100001;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src_in = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [5:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_lat = '0, m_en = '0;

  irq_src_ctl uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] exp_rd();
    return {2'b00, ((m_lat & EDGEM) | (m_s2 & ~EDGEM)) & m_en};
  endfunction

  task automatic check(input string req, input logic [7:0] exp_v);
    checks++;
    if (rd_data !== exp_v) begin
      errors++;
      $display("FAIL %s rd_data actual %h expected %h", req, rd_data, exp_v);
    end
    checks++;
    if (irq !== (exp_v != 0)) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", req, irq, exp_v != 0);
    end
  endtask

  task automatic step(input logic [5:0] s, input logic we, input logic [7:0] wd);
    logic [5:0] k;
    src_in = s; wr_en = we; wr_data = wd;
    @(posedge clk);
    k = we ? wd[5:0] : 6'h3f;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_lat = '0; m_en = '0;
    end else begin
      m_lat = (m_lat | (m_s2 & ~m_prev & EDGEM & m_en)) & k;
      if (we) m_en = wd[5:0];
      m_prev = m_s2; m_s2 = m_s1; m_s1 = s;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    step('0, 0, 0); step('0, 0, 0);
    check("R1", 8'h00);
    rst_n = 1'b1;
    step('0, 0, 0);
    check("R1", 8'h00);

    // R2: write all ones, level bits high, upper bits must stay zero
    step(6'b011110, 1, 8'hff); step(6'b011110, 0, 0); step(6'b011110, 0, 0);
    check("R2", 8'h1e);
    check("R5", exp_rd());

    // R5: level drop clears after two edges, not before
    step(6'b000000, 0, 0);
    check("R5", 8'h1e);
    step(6'b000000, 0, 0);
    check("R5", 8'h00);

    // R3: bit0 rising edge pending on third edge
    step(6'b000001, 0, 0);
    step(6'b000001, 0, 0);
    check("R3", 8'h00);
    step(6'b000001, 0, 0);
    check("R3", 8'h01);
    // R4: held after input falls
    step('0, 0, 0); step('0, 0, 0); step('0, 0, 0);
    check("R4", 8'h01);
    // R7: acknowledge by clearing bit0, then restore
    step('0, 1, 8'h3e);
    check("R7", 8'h00);
    step('0, 1, 8'h3f);
    check("R7", 8'h00);

    // R6: edge on bit5 while disabled
    step('0, 1, 8'h1f);
    step(6'b100000, 0, 0); step(6'b100000, 0, 0); step(6'b100000, 0, 0);
    step(6'b100000, 1, 8'h3f); step(6'b100000, 0, 0);
    check("R6", 8'h00);
    // bit5 new edge while enabled
    step('0, 0, 0); step('0, 0, 0);
    step(6'b100000, 0, 0); step(6'b100000, 0, 0); step(6'b100000, 0, 0);
    check("R3", 8'h20);

    // R9: write zero masks everything
    step(6'b111111, 0, 0); step(6'b111111, 0, 0);
    step(6'b111111, 1, 8'h00);
    check("R9", 8'h00);
    step(6'b111111, 1, 8'h04);
    check("R5", 8'h04);

    // random mix, checked against the model (R8 irq vs rd_data)
    for (int i = 0; i < 2000; i++) begin
      logic [5:0] s;
      logic we;
      s = 6'($urandom);
      we = ($urandom % 6) == 0;
      step(s, we, 8'($urandom));
      check("R8", exp_rd());
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule